// File: doc/BRIEF.md
# Two-Wire Slave with 24-bit Register Access

This block lets an external two-wire (I2C-compatible) bus master reach a register space in which both the register address and the register data are 24 bits wide. The controller oversamples the clock and data lines in the system clock domain. It recognises start, repeated start and stop conditions, and it answers a single 7-bit device address set by a parameter. Each 24-bit field travels on the bus as three bytes, most significant byte first.

A write is one bus transaction. It carries the device address with the direction bit cleared, three address bytes and three data bytes. A read needs two steps. First the master performs an address-only write. Then it issues a repeated start and sends the device address with the direction bit set. The controller fetches the word over its back-side register port and shifts it out in three bytes. The master acknowledges the first two bytes and not the third.

The back-side port is a plain synchronous register strobe interface and has no back-pressure. `reg_wr` and `reg_rd` each last exactly one clock. The attached register file must present `reg_rdata` for `reg_addr` during the cycle in which `reg_rd` is high. `reg_addr` and `reg_wdata` stay stable from the strobe until the next transaction shifts new bytes in.

Top module: `i2c_reg24_slave`

## Requirements
- R1: A start is the synchronised data line falling while the synchronised clock line is high. A stop is the data line rising while the clock line is high. A start is recognised anywhere, including as a repeated start inside a transaction.
- R2: The first byte after a start holds the 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). If bits 7:1 differ from `DEV_ADDR`, that byte is not acknowledged, no strobe is issued, and the bus is ignored until the next start.
- R3: A matching device address byte and each of the following three address bytes and three write data bytes is acknowledged by holding the data line low for the whole ninth clock. Any byte after the third data byte is not acknowledged.
- R4: In a write, address bytes and data bytes arrive most significant byte first. After the acknowledge of the third data byte, `reg_wr` pulses for exactly one clock while `reg_addr` and `reg_wdata` hold the received values.
- R5: A stop or start that arrives before the third data byte has been acknowledged produces no `reg_wr`.
- R6: A matching device address byte with the direction bit set raises `reg_rd` for exactly one clock, with `reg_addr` holding the address from the preceding address-only write. The word on `reg_rdata` in that cycle is the word that will be returned.
- R7: Read data goes out as three bytes, most significant byte first, in order bits 23:16, 15:8, 7:0. `sda_oe` changes only while the synchronised clock line is low.
- R8: After the master does not acknowledge a read byte, `sda_oe` stays low until the next start.
- R9: A start or stop in the middle of a byte abandons the transaction. A following complete transaction is handled normally.
- R10: The behaviour above holds at 100 kHz and 400 kHz bus clock rates with a 50 MHz system clock.
- R11: Out of reset `sda_oe`, `reg_wr` and `reg_rd` are low. `sda_oe` is high only during an acknowledge or a read data bit of value 0. `reg_wr` and `reg_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low (open-drain drive) |
| reg_addr | output | 24 | Register address assembled from the bus |
| reg_wdata | output | 24 | Register write data assembled from the bus |
| reg_wr | output | 1 | One-clock write strobe |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 24 | Read word, valid in the cycle `reg_rd` is high |

## Verification
Two functions can collide in the same system clock: detecting a start or stop, and the byte engine acting on a clock edge in the middle of a byte. The abort path has to win over shifting in the byte. The bench provokes this by placing a repeated start after four bits of an address byte, and a stop after three bits. It judges the result at the ports: no write strobe appears for the abandoned transaction, and the next full write is acknowledged byte by byte and strobes the new address and data. The read path is judged by checking that the returned bytes equal a bench-computed function of the address, and that the data line holds steady across each high half of the bus clock.

// File: rtl/i2c24_pkg.sv
`timescale 1ns/1ps
package i2c24_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } st_e;
endpackage

// File: rtl/i2c24_sync.sv
`timescale 1ns/1ps
module i2c24_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c24_cond.sv
`timescale 1ns/1ps
module i2c24_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // a line change is meaningful as a condition only with SCL high on both samples
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_reg24_slave.sv
`timescale 1ns/1ps
module i2c_reg24_slave
  import i2c24_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         AW          = 24,
  parameter int         DW          = 24,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NAB      = AW / BYTE_W;
  localparam int NDB      = DW / BYTE_W;
  localparam int LAST_IDX = NAB + NDB;
  localparam int IDXW     = $clog2(LAST_IDX + 1);
  localparam int TCW      = $clog2(NDB + 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c24_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  i2c24_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  st_e             state;
  logic [2:0]      bitcnt;
  logic            byte_full;
  logic            accept;
  logic [IDXW-1:0] byte_idx;
  logic [7:0]      rx_sh;
  logic [AW-1:0]   addr_r;
  logic [DW-1:0]   data_r;
  logic [DW-1:0]   tx_sh;
  logic [TCW-1:0]  tx_cnt;
  logic            rd_phase;
  logic            master_ack;
  logic            sda_oe_r, wr_r, rd_r;

  logic [7:0] rx_byte;
  logic       dev_hit, byte_hit;
  assign rx_byte  = {rx_sh[6:0], sda_s};
  assign dev_hit  = (rx_byte[7:1] == DEV_ADDR);
  assign byte_hit = (byte_idx == '0) ? dev_hit : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      byte_full  <= 1'b0;
      accept     <= 1'b0;
      byte_idx   <= '0;
      rx_sh      <= '0;
      addr_r     <= '0;
      data_r     <= '0;
      tx_sh      <= '0;
      tx_cnt     <= '0;
      rd_phase   <= 1'b0;
      master_ack <= 1'b0;
      sda_oe_r   <= 1'b0;
      wr_r       <= 1'b0;
      rd_r       <= 1'b0;
    end else begin
      wr_r <= 1'b0;
      rd_r <= 1'b0;
      if (rd_r) tx_sh <= reg_rdata;

      if (start_det) begin
        state     <= ST_RX;
        bitcnt    <= '0;
        byte_full <= 1'b0;
        byte_idx  <= '0;
        rd_phase  <= 1'b0;
        sda_oe_r  <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        bitcnt    <= '0;
        byte_full <= 1'b0;
        sda_oe_r  <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && !byte_full) begin
              rx_sh <= rx_byte;
              if (bitcnt == 3'd7) begin
                byte_full <= 1'b1;
                accept    <= byte_hit;
                if (byte_idx == '0) begin
                  if (dev_hit && rx_byte[0]) begin
                    rd_phase <= 1'b1;
                    rd_r     <= 1'b1;
                  end
                end else if (byte_idx <= IDXW'(NAB)) begin
                  addr_r <= {addr_r[AW-BYTE_W-1:0], rx_byte};
                end else begin
                  data_r <= {data_r[DW-BYTE_W-1:0], rx_byte};
                end
              end else begin
                bitcnt <= bitcnt + 3'd1;
              end
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bitcnt    <= '0;
              if (accept) begin
                sda_oe_r <= 1'b1;
                state    <= ST_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end

          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_phase) begin
                tx_cnt   <= '0;
                sda_oe_r <= ~tx_sh[DW-1];
                state    <= ST_TX;
              end else if (byte_idx == IDXW'(LAST_IDX)) begin
                wr_r     <= 1'b1;
                sda_oe_r <= 1'b0;
                state    <= ST_IGNORE;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                sda_oe_r <= 1'b0;
                state    <= ST_RX;
              end
            end
          end

          ST_TX: begin
            if (scl_fall) begin
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
              if (bitcnt == 3'd7) begin
                sda_oe_r <= 1'b0;
                state    <= ST_RACK;
              end else begin
                bitcnt   <= bitcnt + 3'd1;
                sda_oe_r <= ~tx_sh[DW-2];
              end
            end
          end

          ST_RACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack && tx_cnt != TCW'(NDB - 1)) begin
                tx_cnt   <= tx_cnt + 1'b1;
                bitcnt   <= '0;
                sda_oe_r <= ~tx_sh[DW-1];
                state    <= ST_TX;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end

          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = sda_oe_r;
  assign reg_wr    = wr_r;
  assign reg_rd    = rd_r;
  assign reg_addr  = addr_r;
  assign reg_wdata = data_r;

  // R4: write strobe is a single clock and follows an acknowledge phase
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r4_wr_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(state) == ST_ACK);
  // R6: read strobe is a single clock and comes out of byte reception
  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  a_r6_rd_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(state) == ST_RX);
  // R7: the data line drive only moves while the clock line is low
  a_r7_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  // R11: strobes never coincide
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: tb/sim_i2c_reg24_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg24_slave;
  localparam logic [6:0] DEV = 7'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_line;
  logic        sda_oe;
  logic [23:0] reg_addr, reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;

  int vectors = 0;
  int errors  = 0;
  int q       = 31;
  int wr_cnt  = 0;
  int rd_cnt  = 0;
  int glitches = 0;
  bit done    = 1'b0;
  logic [23:0] last_waddr, last_wdata, last_raddr;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [23:0] rmodel(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[23:16], a[15:8] + 8'h3C};
  endfunction

  assign reg_rdata = rmodel(reg_addr);

  i2c_reg24_slave u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= reg_addr;
      last_wdata <= reg_wdata;
    end
    if (reg_rd) begin
      rd_cnt     <= rd_cnt + 1;
      last_raddr <= reg_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(q);
    scl = 1'b1;   tick(q);
    sda_m = 1'b0; tick(q);
    scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(q); sda_m = 1'b0; tick(q);
    scl = 1'b1; tick(q);
    sda_m = 1'b1; tick(q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(q); sda_m = b[i];
      tick(q); scl = 1'b1;
      tick(2 * q); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    tick(q); sda_m = 1'b1;
    tick(q); scl = 1'b1;
    tick(q); ack = ~sda_line;
    tick(q); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      tick(q); sda_m = 1'b1;
      tick(q); scl = 1'b1;
      tick(q); s1 = sda_line;
      tick(q - 1); s2 = sda_line;
      if (s1 != s2) glitches++;
      b[i] = s1;
      tick(1); scl = 1'b0;
    end
    tick(q); sda_m = ~give_ack;
    tick(q); scl = 1'b1;
    tick(2 * q); scl = 1'b0;
  endtask

  task automatic do_write(input logic [23:0] a, input logic [23:0] d, input bit extra, input string tag);
    bit ak;
    int w0;
    w0 = wr_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, ak); chk(ak, {"R3 dev ack ", tag}, ak, 1);
    for (int k = 2; k >= 0; k--) begin
      send_byte(a[k*8 +: 8], ak); chk(ak, {"R3 addr ack ", tag}, ak, 1);
    end
    for (int k = 2; k >= 0; k--) begin
      send_byte(d[k*8 +: 8], ak); chk(ak, {"R3 data ack ", tag}, ak, 1);
    end
    if (extra) begin
      send_byte(8'h5A, ak); chk(!ak, {"R3 extra byte nack ", tag}, ak, 0);
    end
    bus_stop;
    tick(4);
    chk(wr_cnt == w0 + 1, {"R4 one write strobe ", tag}, wr_cnt - w0, 1);
    chk(last_waddr == a, {"R4 write addr ", tag}, last_waddr, a);
    chk(last_wdata == d, {"R4 write data ", tag}, last_wdata, d);
  endtask

  task automatic do_read(input logic [23:0] a, input string tag);
    bit ak;
    logic [7:0] b;
    logic [23:0] got;
    int r0, g0;
    r0 = rd_cnt;
    g0 = glitches;
    bus_start;
    send_byte({DEV, 1'b0}, ak); chk(ak, {"R3 dummy dev ack ", tag}, ak, 1);
    for (int k = 2; k >= 0; k--) begin
      send_byte(a[k*8 +: 8], ak); chk(ak, {"R3 dummy addr ack ", tag}, ak, 1);
    end
    bus_start;
    send_byte({DEV, 1'b1}, ak); chk(ak, {"R6 read dev ack ", tag}, ak, 1);
    chk(rd_cnt == r0 + 1, {"R6 one read strobe ", tag}, rd_cnt - r0, 1);
    chk(last_raddr == a, {"R6 read addr ", tag}, last_raddr, a);
    recv_byte(1'b1, b); got[23:16] = b;
    recv_byte(1'b1, b); got[15:8]  = b;
    recv_byte(1'b0, b); got[7:0]   = b;
    chk(got == rmodel(a), {"R7 read word ", tag}, got, rmodel(a));
    chk(glitches == g0, {"R7 sda steady while scl high ", tag}, glitches - g0, 0);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, {"R8 released after nack ", tag}, b, 8'hFF);
    bus_stop;
  endtask

  initial begin
    repeat (1 + 195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    int w0;
    tick(5);
    chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R11 reset outputs",
        {sda_oe, reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    tick(5);

    // R4 R10 fast-mode write sweep with computed patterns
    for (int k = 0; k < 3; k++) begin
      logic [23:0] a, d;
      a = 24'h13579B + 24'h2468AC * k[23:0];
      d = {a[11:0], ~a[23:12]} ^ (24'h800001 >> k);
      do_write(a, d, 1'b0, "sweep");
    end

    // R6 R7 R8 reads back at fast mode
    do_read(24'hC0FFEE, "fast a");
    do_read(24'h00FF01, "fast b");

    // R2 device address mismatch
    w0 = wr_cnt;
    bus_start;
    send_byte({7'h2D, 1'b0}, ak); chk(!ak, "R2 mismatch nack", ak, 0);
    send_byte(8'h11, ak);         chk(!ak, "R2 ignored after mismatch", ak, 0);
    send_byte(8'h22, ak);
    send_byte(8'h33, ak);
    send_byte(8'h44, ak);
    send_byte(8'h55, ak);
    send_byte(8'h66, ak);
    bus_stop;
    tick(4);
    chk(wr_cnt == w0, "R2 no strobe on mismatch", wr_cnt - w0, 0);

    // R5 stop before third data byte
    w0 = wr_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'hAA, ak); send_byte(8'hBB, ak); send_byte(8'hCC, ak);
    send_byte(8'h01, ak); send_byte(8'h02, ak);
    bus_stop;
    tick(4);
    chk(wr_cnt == w0, "R5 partial write dropped", wr_cnt - w0, 0);

    // R1 R9 repeated start after four bits of an address byte
    bus_start;
    send_byte({DEV, 1'b0}, ak);
    send_bits(8'hF0, 4);
    do_write(24'h5A5A5A, 24'h123456, 1'b0, "R9 after mid-byte start");

    // R9 stop after three bits of an address byte
    w0 = wr_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h77, ak);
    send_bits(8'hE0, 3);
    bus_stop;
    tick(4);
    chk(wr_cnt == w0, "R9 mid-byte stop no strobe", wr_cnt - w0, 0);
    do_write(24'hABCDEF, 24'hFEDCBA, 1'b1, "R3 extra byte");

    // R10 normal mode read
    q = 125;
    do_read(24'h3C4D5E, "R10 normal");

    chk(sda_oe == 1'b0, "R11 idle release", sda_oe, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule